// File: doc/BRIEF.md
# Gated High-Speed Pulse Counter

This block keeps a signed present value for one high-speed pulse channel. Each clock, a count-enable input paired with an up/down input moves the value by one step. Several controls act on that step:

- A gate input can freeze the count.
- A software reset bit can clear the count in one of two ways, chosen by a method select.
- A preset port loads a new value, standing in for a host write.
- A counting-mode select chooses between two behaviours. Linear mode saturates at the signed limits and raises an overflow/underflow flag. Wrap mode rolls over with no flag.

The live value is not visible directly. On each scan-cycle strobe, the block captures the present value and the flag to its outputs. It also derives a direction flag by comparing the new capture with the previous one.

The preset port is a plain valid-qualified load. It has no ready signal and is accepted on every clock in which it is valid, so it never applies back-pressure. All other pins are plain level controls sampled on the rising clock edge.

Top module: `hsc_pv_counter`

## Requirements
- R1: After reset (rst_n low), pv_out is 0, ovf_flag is 0 and dir_flag is 1.
- R2: Each clock with cnt_en=1 and no clear, load or hold changes the live value by +1 if cnt_up=1, or by -1 if cnt_up=0.
- R3: With rst_sel=1 (software-only method), the live value becomes 0 on the clock where sw_rst goes from 0 to 1. Holding sw_rst at 1 gives no further clears.
- R4: With rst_sel=0 (marker method), a rising edge of z_in while sw_rst=1 clears the live value to 0. A z_in edge while sw_rst=0 does nothing, a sw_rst edge alone does nothing, and z_in held high clears only once.
- R5: While gate=1, count pulses leave the live value unchanged. Counting resumes when gate returns to 0.
- R6: With rst_sel=0 and sw_rst=1, gate has no effect and pulses count. With rst_sel=1, gate still holds while sw_rst=1.
- R7: In linear mode (mode_sel=0), a step beyond +2^31-1 or below -2^31 leaves the value at that limit and sets the overflow flag. While the flag is 1, pulses do not change the value.
- R8: In wrap mode (mode_sel=1), the value rolls over in two's complement and the overflow flag stays 0.
- R9: The overflow flag is cleared by a run_start pulse, by a preset load and by a counter clear.
- R10: A valid preset (preset_vld=1) sets the live value to preset_val. A clear in the same clock wins over both a load and a count pulse, and gives 0.
- R11: pv_out and ovf_flag change only on the clock after scan_strb=1, and then show the live value and flag as they were at that edge.
- R12: On a strobe, dir_flag becomes 1 if the captured value is greater (signed) than the previous pv_out, 0 if it is smaller, and keeps its value if the two are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count pulse for this clock |
| cnt_up | input | 1 | Direction of the pulse: 1 up, 0 down |
| z_in | input | 1 | Marker input, edge-detected |
| sw_rst | input | 1 | Software reset bit |
| gate | input | 1 | Count hold bit |
| rst_sel | input | 1 | Reset method: 0 marker qualified by sw_rst, 1 sw_rst rising edge |
| mode_sel | input | 1 | Counting mode: 0 linear, 1 wrap |
| run_start | input | 1 | Operation-start pulse; clears overflow flag |
| preset_vld | input | 1 | Load preset_val this clock |
| preset_val | input | 32 | Value to load |
| scan_strb | input | 1 | Scan-cycle capture strobe |
| pv_out | output | 32 | Captured present value |
| ovf_flag | output | 1 | Captured overflow/underflow flag |
| dir_flag | output | 1 | Direction from the last two captures |

## Verification
Counting is exercised with runs of up pulses, runs of down pulses and pauses with no pulses. The resulting captures separate a correct step from a sign error, and the equal-value capture shows that direction is held rather than recomputed. Gate and reset controls are tried in both reset methods. This distinguishes a gate that is overridden only in the marker method from one overridden always or never, and a clear on an edge from a clear on a level. Values preset near both signed limits tell saturation with a frozen value apart from two's complement rollover, and a clear landing with a load or a pulse in the same clock shows which one wins.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic {
    RM_ZMARK = 1'b0,
    RM_SOFT  = 1'b1
  } rst_method_e;

  typedef enum logic {
    CM_LINEAR = 1'b0,
    CM_WRAP   = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/hsc_rst_ctrl.sv
module hsc_rst_ctrl
  import hsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        z_in,
  input  logic        sw_rst,
  input  rst_method_e method,
  output logic        clr,
  output logic        gate_ovr
);
  logic z_q, sw_q;
  logic z_rise, sw_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q  <= 1'b0;
      sw_q <= 1'b0;
    end else begin
      z_q  <= z_in;
      sw_q <= sw_rst;
    end
  end

  assign z_rise  = z_in & ~z_q;
  assign sw_rise = sw_rst & ~sw_q;

  always_comb begin
    if (method == RM_ZMARK) begin
      clr      = z_rise & sw_rst;
      gate_ovr = sw_rst;
    end else begin
      clr      = sw_rise;
      gate_ovr = 1'b0;
    end
  end

  AST_CLEAR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !clr); // R4
  AST_SOFT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (method == RM_SOFT && sw_rst && $past(sw_rst)) |-> !clr); // R3
endmodule

// File: rtl/hsc_pv_core.sv
module hsc_pv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step_en,
  input  logic         step_up,
  input  logic         ld_vld,
  input  logic [W-1:0] ld_val,
  input  logic         run_start,
  input  logic         linear,
  output logic [W-1:0] pv,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] pv_d;
  logic         ovf_d;

  always_comb begin
    pv_d  = pv;
    ovf_d = ovf;
    if (clr) begin
      pv_d  = '0;
      ovf_d = 1'b0;
    end else if (ld_vld) begin
      pv_d  = ld_val;
      ovf_d = 1'b0;
    end else begin
      if (run_start) ovf_d = 1'b0;
      if (step_en && !(linear && ovf)) begin
        if (step_up) begin
          if (linear && pv == MAXV) ovf_d = 1'b1;
          else                      pv_d  = pv + 1'b1;
        end else begin
          if (linear && pv == MINV) ovf_d = 1'b1;
          else                      pv_d  = pv - 1'b1;
        end
      end
    end
    if (!linear) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv  <= '0;
      ovf <= 1'b0;
    end else begin
      pv  <= pv_d;
      ovf <= ovf_d;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pv == '0 && !ovf)); // R10
  AST_SAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (linear && ovf && !clr && !ld_vld) |=> $stable(pv)); // R7
  AST_WRAP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !linear |=> !ovf); // R8
  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && !clr) |=> (pv == $past(ld_val) && !ovf)); // R9
endmodule

// File: rtl/hsc_scan_sample.sv
module hsc_scan_sample #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strb,
  input  logic [W-1:0] pv_live,
  input  logic         ovf_live,
  output logic [W-1:0] pv_out,
  output logic         ovf_out,
  output logic         dir_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_out  <= '0;
      ovf_out <= 1'b0;
      dir_out <= 1'b1;
    end else if (strb) begin
      pv_out  <= pv_live;
      ovf_out <= ovf_live;
      if ($signed(pv_live) > $signed(pv_out))      dir_out <= 1'b1;
      else if ($signed(pv_live) < $signed(pv_out)) dir_out <= 1'b0;
    end
  end

  AST_DIR_EQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && pv_live == pv_out) |=> $stable(dir_out)); // R12
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb |=> ($stable(pv_out) && $stable(ovf_out) && $stable(dir_out))); // R11
endmodule

// File: rtl/hsc_pv_counter.sv
module hsc_pv_counter
  import hsc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         cnt_up,
  input  logic         z_in,
  input  logic         sw_rst,
  input  logic         gate,
  input  logic         rst_sel,
  input  logic         mode_sel,
  input  logic         run_start,
  input  logic         preset_vld,
  input  logic [W-1:0] preset_val,
  input  logic         scan_strb,
  output logic [W-1:0] pv_out,
  output logic         ovf_flag,
  output logic         dir_flag
);
  rst_method_e  method;
  cnt_mode_e    mode;
  logic         clr, gate_ovr, step_en;
  logic [W-1:0] pv_live;
  logic         ovf_live;

  assign method  = rst_method_e'(rst_sel);
  assign mode    = cnt_mode_e'(mode_sel);
  assign step_en = cnt_en & (~gate | gate_ovr);

  hsc_rst_ctrl u_rst (
    .clk(clk), .rst_n(rst_n), .z_in(z_in), .sw_rst(sw_rst),
    .method(method), .clr(clr), .gate_ovr(gate_ovr)
  );

  hsc_pv_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step_en(step_en),
    .step_up(cnt_up), .ld_vld(preset_vld), .ld_val(preset_val),
    .run_start(run_start), .linear(mode == CM_LINEAR),
    .pv(pv_live), .ovf(ovf_live)
  );

  hsc_scan_sample #(.W(W)) u_scan (
    .clk(clk), .rst_n(rst_n), .strb(scan_strb), .pv_live(pv_live),
    .ovf_live(ovf_live), .pv_out(pv_out), .ovf_out(ovf_flag),
    .dir_out(dir_flag)
  );

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !(rst_sel == 1'b0 && sw_rst) && !clr && !preset_vld) |=> $stable(pv_live)); // R5
  AST_GATE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sel == 1'b0 && sw_rst && cnt_en && !clr && !preset_vld && mode_sel && !run_start)
      |=> (pv_live != $past(pv_live))); // R6
endmodule

// File: tb/sim_hsc_pv_counter.sv
module sim_hsc_pv_counter;
  localparam logic [31:0] MAXV = 32'h7FFF_FFFF;
  localparam logic [31:0] MINV = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 0, cnt_up = 0, z_in = 0, sw_rst = 0, gate = 0;
  logic rst_sel = 0, mode_sel = 0, run_start = 0, preset_vld = 0, scan_strb = 0;
  logic [31:0] preset_val = '0;
  logic [31:0] pv_out;
  logic ovf_flag, dir_flag;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hsc_pv_counter u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up), .z_in(z_in),
    .sw_rst(sw_rst), .gate(gate), .rst_sel(rst_sel), .mode_sel(mode_sel),
    .run_start(run_start), .preset_vld(preset_vld), .preset_val(preset_val),
    .scan_strb(scan_strb), .pv_out(pv_out), .ovf_flag(ovf_flag), .dir_flag(dir_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulses(input int n, input logic up);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1'b1; cnt_up = up;
    end
    @(negedge clk); cnt_en = 1'b0;
  endtask

  task automatic sample();
    @(negedge clk); scan_strb = 1'b1;
    @(negedge clk); scan_strb = 1'b0;
  endtask

  task automatic load(input logic [31:0] v);
    @(negedge clk); preset_vld = 1'b1; preset_val = v;
    @(negedge clk); preset_vld = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pv", pv_out, 0);
    chk("R1 ovf", {31'b0, ovf_flag}, 0);
    chk("R1 dir", {31'b0, dir_flag}, 1);
  endtask

  task automatic t_count();
    pulses(5, 1'b1);
    chk("R11 no strobe", pv_out, 0);
    sample();
    chk("R2 up", pv_out, 5);
    chk("R12 inc", {31'b0, dir_flag}, 1);
    pulses(2, 1'b0);
    sample();
    chk("R2 down", pv_out, 3);
    chk("R12 dec", {31'b0, dir_flag}, 0);
    sample();
    chk("R12 equal hold", {31'b0, dir_flag}, 0);
  endtask

  task automatic t_soft_reset();
    rst_sel = 1'b1;
    load(10);
    @(negedge clk); sw_rst = 1'b1;
    pulses(3, 1'b1);
    sample();
    chk("R3 one clear then count", pv_out, 3);
    @(negedge clk); sw_rst = 1'b0;
  endtask

  task automatic t_zmark();
    rst_sel = 1'b0;
    load(7);
    @(negedge clk); z_in = 1'b1;
    @(negedge clk); z_in = 1'b0;
    @(negedge clk); sw_rst = 1'b1;
    sample();
    chk("R4 no clear without both", pv_out, 7);
    @(negedge clk); z_in = 1'b1;
    pulses(2, 1'b1);
    sample();
    chk("R4 single clear with z held", pv_out, 2);
    @(negedge clk); z_in = 1'b0; sw_rst = 1'b0;
  endtask

  task automatic t_gate();
    rst_sel = 1'b1;
    load(20);
    @(negedge clk); gate = 1'b1;
    pulses(4, 1'b1);
    sample();
    chk("R5 held", pv_out, 20);
    @(negedge clk); gate = 1'b0;
    pulses(1, 1'b1);
    sample();
    chk("R5 resumed", pv_out, 21);
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); gate = 1'b1;
    pulses(3, 1'b1);
    sample();
    chk("R6 soft method gate holds", pv_out, 0);
    @(negedge clk); sw_rst = 1'b0; rst_sel = 1'b0;
    @(negedge clk); sw_rst = 1'b1;
    pulses(3, 1'b1);
    @(negedge clk); sw_rst = 1'b0;
    pulses(2, 1'b1);
    sample();
    chk("R6 marker method override", pv_out, 3);
    @(negedge clk); gate = 1'b0;
  endtask

  task automatic t_linear_sat();
    mode_sel = 1'b0; rst_sel = 1'b1;
    load(MAXV - 2);
    pulses(5, 1'b1);
    sample();
    chk("R7 sat max", pv_out, MAXV);
    chk("R7 ovf set", {31'b0, ovf_flag}, 1);
    pulses(3, 1'b0);
    sample();
    chk("R7 frozen", pv_out, MAXV);
    @(negedge clk); run_start = 1'b1;
    @(negedge clk); run_start = 1'b0;
    pulses(1, 1'b0);
    sample();
    chk("R9 start clears", {31'b0, ovf_flag}, 0);
    chk("R9 counts after start", pv_out, MAXV - 1);
    load(MINV + 1);
    pulses(3, 1'b0);
    sample();
    chk("R7 sat min", pv_out, MINV);
    chk("R7 underflow flag", {31'b0, ovf_flag}, 1);
    load(5);
    sample();
    chk("R9 preset clears", {31'b0, ovf_flag}, 0);
    chk("R10 preset value", pv_out, 5);
    load(MINV);
    pulses(1, 1'b0);
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    sample();
    chk("R9 clear resets flag", {31'b0, ovf_flag}, 0);
    chk("R9 clear value", pv_out, 0);
  endtask

  task automatic t_wrap();
    mode_sel = 1'b1;
    load(MAXV);
    pulses(2, 1'b1);
    sample();
    chk("R8 wrap up", pv_out, MINV + 1);
    chk("R8 no flag", {31'b0, ovf_flag}, 0);
    pulses(2, 1'b0);
    sample();
    chk("R8 wrap down", pv_out, MAXV);
    mode_sel = 1'b0;
  endtask

  task automatic t_priority();
    rst_sel = 1'b1;
    load(9);
    @(negedge clk); sw_rst = 1'b1; cnt_en = 1'b1; cnt_up = 1'b1;
    @(negedge clk); cnt_en = 1'b0; sw_rst = 1'b0;
    sample();
    chk("R10 clear beats count", pv_out, 0);
    load(9);
    @(negedge clk); sw_rst = 1'b1; preset_vld = 1'b1; preset_val = 44;
    @(negedge clk); preset_vld = 1'b0; sw_rst = 1'b0;
    sample();
    chk("R10 clear beats load", pv_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_soft_reset();
    t_zmark();
    t_gate();
    t_linear_sat();
    t_wrap();
    t_priority();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule